// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block regulates the current in one motor winding by steering the four switches of an H-bridge. A 4-bit current code scales a reference level into a threshold. A digitised, unsigned winding-current sample is compared against that threshold once per clock. When the sample rises above the threshold, a fixed off-time of a programmable number of cycles begins. During the off-time the sink switch of the conducting diagonal is released, so the winding recirculates through the upper path. When the off-time ends, the sink switch returns. Chopping therefore happens only while the current actually reaches the threshold.

Direction and brake inputs select which switches conduct. Brake closes both upper switches and short-circuits the winding. Over-temperature and undervoltage inputs open every switch. A dead-time stage sits between the decoded switch pattern and the gate outputs. It opens a switch at the next clock edge, but closes a switch only after a fixed number of quiet cycles. This prevents both switches of one half-bridge from conducting at the same time. The analog sensing, the converters and the power stage lie outside the block.

Top module: `chop_ctrl`

## Requirements
- R1: The threshold is floor(ref_level * cur_code / 16), where cur_code is unsigned and bit 3 is its most significant bit. An off-time starts only when cur_sample is strictly greater than the threshold. A sample equal to the threshold starts nothing.
- R2: An off-time lasts off_cycles clock cycles. The sink gate of the conducting diagonal falls three edges after the sample first exceeds the threshold. It stays low for exactly off_cycles + DEAD_CYC sampled cycles. The source gate of that diagonal stays on throughout.
- R3: A threshold crossing that occurs while an off-time is running is ignored. It neither restarts nor extends the off-time.
- R4: With brake high and no fault, gate_src1 and gate_src2 are on and both sink gates are off, whatever the direction or off-time state.
- R5: With brake low, no fault and no off-time, dir = 1 selects gate_src2 with gate_snk1, and dir = 0 selects gate_src1 with gate_snk2. During an off-time only the source gate of that pair stays on.
- R6: A gate that the decoded pattern no longer wants opens at the next clock edge. A gate turns on only after DEAD_CYC + 1 edges in which no gate opened. A direction reversal therefore shows exactly DEAD_CYC + 1 sampled cycles with all gates off.
- R7: A high level on fault_ot or on fault_uv opens all four gates at the next clock edge. After both faults clear, normal switching resumes.
- R8: With rst_n low at a clock edge, the off-timer is cleared and all four gates are off.
- R9: gate_src1 and gate_snk1 are never on together, and gate_src2 and gate_snk2 are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_level | input | REF_W | Full-scale reference level |
| cur_code | input | 4 | Current code, bit 3 is the MSB |
| cur_sample | input | SAMPLE_W | Digitised winding current, unsigned |
| off_cycles | input | OFF_W | Off-time length in clock cycles |
| brake | input | 1 | Brake request |
| dir | input | 1 | Current direction select |
| fault_ot | input | 1 | Over-temperature fault |
| fault_uv | input | 1 | Supply undervoltage fault |
| gate_src1 | output | 1 | Upper switch, half-bridge 1 |
| gate_snk1 | output | 1 | Lower switch, half-bridge 1 |
| gate_src2 | output | 1 | Upper switch, half-bridge 2 |
| gate_snk2 | output | 1 | Lower switch, half-bridge 2 |

## Verification
The bench builds the block with 10-bit reference and sample words, a 16-bit off-time register and DEAD_CYC = 3. With these values the threshold can be taken to both ends of the code range: code 0 gives a threshold of zero, and code 15 at a full-scale reference of 1023 gives a threshold that rounds down to 959. The short dead time makes an exact measurement of the sink-gate low window practical. That window combines a 20-cycle off-time with the three-cycle dead band. The bench also counts the all-off window on a direction reversal.

// File: rtl/chop_pkg.sv
package chop_pkg;

  localparam int CODE_W = 4;

  typedef struct packed {
    logic src1;
    logic snk1;
    logic src2;
    logic snk2;
  } gates_t;

  // Switch pattern requested by the control inputs, before dead-time shaping.
  function automatic gates_t bridge_pattern(input logic brk, input logic dir_i,
                                            input logic off_on, input logic flt);
    gates_t g;
    g = '0;
    if (flt) begin
      g = '0;
    end else if (brk) begin
      g.src1 = 1'b1;
      g.src2 = 1'b1;
    end else if (dir_i) begin
      g.src2 = 1'b1;
      g.snk1 = !off_on;
    end else begin
      g.src1 = 1'b1;
      g.snk2 = !off_on;
    end
    return g;
  endfunction

endpackage

// File: rtl/chop_offtimer.sv
module chop_offtimer #(
  parameter int REF_W    = 10,
  parameter int SAMPLE_W = 10,
  parameter int OFF_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [REF_W-1:0]          ref_level,
  input  logic [chop_pkg::CODE_W-1:0] cur_code,
  input  logic [SAMPLE_W-1:0]       cur_sample,
  input  logic [OFF_W-1:0]          off_cycles,
  output logic                      off_active
);
  localparam int PROD_W = REF_W + chop_pkg::CODE_W;
  localparam int CMP_W  = (SAMPLE_W > REF_W) ? SAMPLE_W : REF_W;

  logic [PROD_W-1:0] prod;
  logic [CMP_W-1:0]  thr_ext;
  logic [CMP_W-1:0]  smp_ext;
  logic              over_now;
  logic              over_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              trig;

  assign prod     = PROD_W'(ref_level) * PROD_W'(cur_code);
  assign thr_ext  = CMP_W'(prod[PROD_W-1:chop_pkg::CODE_W]);
  assign smp_ext  = CMP_W'(cur_sample);
  assign over_now = smp_ext > thr_ext;
  assign trig     = over_q && (cnt_q == '0);
  assign off_active = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      over_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      over_q <= over_now;
      if (trig)
        cnt_q <= off_cycles;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (cnt_q == '0));

endmodule

// File: rtl/chop_deadband.sv
module chop_deadband #(
  parameter int DEAD_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chop_pkg::gates_t target,
  output chop_pkg::gates_t gates
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_LD = DW'(DEAD_CYC);

  logic [3:0]    gates_q;
  logic [3:0]    want;
  logic [3:0]    drop;
  logic [3:0]    add;
  logic [DW-1:0] dcnt_q;

  assign want = target;
  assign drop = gates_q & ~want;
  assign add  = want & ~gates_q;
  assign gates = gates_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gates_q <= '0;
      dcnt_q  <= DEAD_LD;
    end else if (drop != '0) begin
      gates_q <= gates_q & want;
      dcnt_q  <= DEAD_LD;
    end else if (add != '0) begin
      if (dcnt_q != '0)
        dcnt_q <= dcnt_q - 1'b1;
      else
        gates_q <= want;
    end else begin
      dcnt_q <= DEAD_LD;
    end
  end

  // Independent watch of the gap since the last gate opened.
  localparam int SW = DW + 1;
  logic [3:0]    prev_q;
  logic [SW-1:0] since_q;
  logic          fell_w;
  logic          rose_w;
  assign fell_w = |(prev_q & ~gates_q);
  assign rose_w = |(gates_q & ~prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      since_q <= SW'(DEAD_CYC + 1);
    end else begin
      prev_q <= gates_q;
      if (fell_w)
        since_q <= '0;
      else if (since_q < SW'(DEAD_CYC + 1))
        since_q <= since_q + 1'b1;
    end
  end

  // R6
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rose_w |-> (since_q >= SW'(DEAD_CYC)));

  // R9
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates_q[3] && gates_q[2]) && !(gates_q[1] && gates_q[0]));

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl #(
  parameter int REF_W    = 10,
  parameter int SAMPLE_W = 10,
  parameter int OFF_W    = 16,
  parameter int DEAD_CYC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REF_W-1:0]    ref_level,
  input  logic [3:0]          cur_code,
  input  logic [SAMPLE_W-1:0] cur_sample,
  input  logic [OFF_W-1:0]    off_cycles,
  input  logic                brake,
  input  logic                dir,
  input  logic                fault_ot,
  input  logic                fault_uv,
  output logic                gate_src1,
  output logic                gate_snk1,
  output logic                gate_src2,
  output logic                gate_snk2
);
  import chop_pkg::*;

  logic   off_active;
  logic   fault_any;
  gates_t pattern;
  gates_t gates;

  chop_offtimer #(.REF_W(REF_W), .SAMPLE_W(SAMPLE_W), .OFF_W(OFF_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_level  (ref_level),
    .cur_code   (cur_code),
    .cur_sample (cur_sample),
    .off_cycles (off_cycles),
    .off_active (off_active)
  );

  assign fault_any = fault_ot || fault_uv;
  assign pattern   = bridge_pattern(brake, dir, off_active, fault_any);

  chop_deadband #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk    (clk),
    .rst_n  (rst_n),
    .target (pattern),
    .gates  (gates)
  );

  assign gate_src1 = gates.src1;
  assign gate_snk1 = gates.snk1;
  assign gate_src2 = gates.src2;
  assign gate_snk2 = gates.snk2;

  // R7
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ot || fault_uv) |=> !(gate_src1 || gate_snk1 || gate_src2 || gate_snk2));

  // R4
  brake_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brake && !fault_ot && !fault_uv) |=> !(gate_snk1 || gate_snk2));

  // R2
  off_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_active) |=> !gate_snk1 && !gate_snk2);

  // R8
  rst_gates_chk: assert property (@(posedge clk)
    !rst_n |=> !(gate_src1 || gate_snk1 || gate_src2 || gate_snk2));

endmodule

// File: tb/tb_chop_ctrl.sv
module tb_chop_ctrl;
  localparam int DEAD = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] ref_level;
  logic [3:0] cur_code;
  logic [9:0] cur_sample;
  logic [15:0] off_cycles;
  logic       brake, dir, fault_ot, fault_uv;
  logic       gate_src1, gate_snk1, gate_src2, gate_snk2;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  chop_ctrl #(.REF_W(10), .SAMPLE_W(10), .OFF_W(16), .DEAD_CYC(DEAD)) dut (
    .clk(clk), .rst_n(rst_n), .ref_level(ref_level), .cur_code(cur_code),
    .cur_sample(cur_sample), .off_cycles(off_cycles), .brake(brake), .dir(dir),
    .fault_ot(fault_ot), .fault_uv(fault_uv), .gate_src1(gate_src1),
    .gate_snk1(gate_snk1), .gate_src2(gate_src2), .gate_snk2(gate_snk2));

  function automatic logic [3:0] gv();
    return {gate_src1, gate_snk1, gate_src2, gate_snk2};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((gate_src1 && gate_snk1) || (gate_src2 && gate_snk2)) begin
        errors++;
        $display("FAIL R9: actual %b expected no half-bridge overlap", gv());
      end
    end
  endtask

  // Threshold computed by the bench: floor(ref*code/16).
  function automatic int bench_thr(input int r, input int c);
    return (r * c) / 16;
  endfunction

  // Returns the number of negedges until the sink falls, or -1 within limit.
  task automatic wait_sink_fall(input int limit, output int lat);
    lat = -1;
    for (int i = 1; i <= limit; i++) begin
      tick(1);
      if (!gate_snk1) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_level = 10'd800; cur_code = 4'd8; cur_sample = '0;
    off_cycles = 16'd20; brake = 0; dir = 1; fault_ot = 0; fault_uv = 0;
    tick(3);
    // R8
    check("R8 gates in reset", gv(), 0);
    rst_n = 1'b1;
    tick(12);
  endtask

  task automatic t_direction();
    dir = 1; tick(12);
    // R5
    check("R5 dir=1 pattern", gv(), 4'b0110);
    dir = 0;
    begin
      int off_cnt = 0;
      for (int i = 0; i < 12; i++) begin
        tick(1);
        if (gv() == 4'b0000) off_cnt++;
      end
      // R6
      check("R6 reversal all-off cycles", off_cnt, DEAD + 1);
    end
    check("R5 dir=0 pattern", gv(), 4'b1001);
    dir = 1; tick(12);
  endtask

  task automatic t_chop();
    int lat, width;
    off_cycles = 16'd20; ref_level = 10'd800; cur_code = 4'd8;
    cur_sample = 10'(bench_thr(800, 8) + 1);
    wait_sink_fall(10, lat);
    // R2
    check("R2 sink fall latency", lat, 3);
    check("R2 source held", gate_src2, 1);
    cur_sample = 10'd100;
    width = 1;
    for (int i = 0; i < 60; i++) begin
      if (i == 5) cur_sample = 10'd1000;
      if (i == 7) cur_sample = 10'd100;
      tick(1);
      if (gate_snk1) break;
      width++;
    end
    // R2, R3: mid off-time crossing must not stretch the window
    check("R2/R3 sink low width", width, 20 + DEAD);
    tick(5);
    check("R3 no further chop", gv(), 4'b0110);
  endtask

  task automatic probe(input int r, input int c, input int s, input int exp, input string req);
    int lat;
    ref_level = 10'(r); cur_code = 4'(c); off_cycles = 16'd6;
    tick(3);
    cur_sample = 10'(s);
    wait_sink_fall(6, lat);
    check(req, (lat > 0) ? 1 : 0, exp);
    cur_sample = '0;
    tick(16);
  endtask

  task automatic t_threshold();
    // R1
    probe(800, 8, bench_thr(800, 8), 0, "R1 equal to threshold");
    probe(1023, 15, bench_thr(1023, 15), 0, "R1 code15 at 959");
    probe(1023, 15, bench_thr(1023, 15) + 1, 1, "R1 code15 above");
    probe(1023, 0, 0, 0, "R1 code0 sample0");
    probe(1023, 0, 1, 1, "R1 code0 sample1");
    probe(512, 1, 33, 1, "R1 code1 above 32");
    probe(512, 1, 32, 0, "R1 code1 equal 32");
  endtask

  task automatic t_brake();
    brake = 1; tick(1);
    // R4
    check("R4 sinks drop next edge", {gate_snk1, gate_snk2}, 0);
    tick(10);
    check("R4 brake pattern", gv(), 4'b1010);
    cur_sample = 10'd1000; dir = 0; tick(8);
    check("R4 brake ignores dir/off", gv(), 4'b1010);
    cur_sample = '0; brake = 0; dir = 1; tick(40);
    check("R5 after brake", gv(), 4'b0110);
  endtask

  task automatic t_fault();
    fault_ot = 1; tick(1);
    // R7
    check("R7 over-temp opens all", gv(), 0);
    tick(5); fault_ot = 0; tick(12);
    check("R7 resume after ot", gv(), 4'b0110);
    fault_uv = 1; brake = 1; tick(1);
    check("R7 undervoltage opens all", gv(), 0);
    fault_uv = 0; brake = 0; tick(12);
    check("R7 resume after uv", gv(), 4'b0110);
    rst_n = 0; tick(1);
    check("R8 mid-run reset", gv(), 0);
    rst_n = 1; tick(12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_direction();
    t_chop();
    t_threshold();
    t_brake();
    t_fault();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule